// File: doc/BRIEF.md
# Read-Modify-Write Store Merger

This block sits in front of a data RAM one doubleword (64 bits) wide. It builds the value to write for byte, word and doubleword stores. The RAM has no per-byte write enables. A narrow store therefore reads the doubleword at the target address and writes a spliced copy of it back in the same clock cycle. The merger takes the doubleword the RAM currently returns, the store operand and the byte offset inside the doubleword. It then replaces only the addressed lane. It also drives the RAM read and write enables for the store.

The block is purely combinational. The RAM's registered write at the next clock edge commits the store. The doubleword address is formed outside the block. Load extraction is also handled elsewhere. A read enable raised by this block is meant to be ORed with the load path's own read request.

Top module: `rmw_store_merge`

## Requirements
- R1: While `st_en` is 0, `ram_wr_en` and `ram_rd_en` are both 0, whatever the other inputs hold.
- R2: A doubleword store (`st_size` = 2'b11) drives `wr_data` equal to `st_data`, with `ram_wr_en` = 1 and `ram_rd_en` = 0.
- R3: A word store (`st_size` = 2'b10) with `byte_off[2]` = 0 places `st_data[31:0]` in `wr_data[31:0]` and passes `cur_dw[63:32]` to `wr_data[63:32]`.
- R4: A word store with `byte_off[2]` = 1 places `st_data[31:0]` in `wr_data[63:32]` and passes `cur_dw[31:0]` to `wr_data[31:0]`.
- R5: A byte store (`st_size` = 2'b00) places `st_data[7:0]` in byte lane `byte_off` (bits 8*`byte_off`+7 down to 8*`byte_off`) and passes the other seven lanes from `cur_dw`.
- R6: Byte and word stores assert `ram_rd_en` and `ram_wr_en` together in the same cycle.
- R7: The code `st_size` = 2'b01 is reserved: with `st_en` = 1 it leaves both enables at 0, so the RAM contents do not change.
- R8: For a word store `byte_off[1:0]` has no effect on `wr_data`, and for a doubleword store `byte_off` has no effect at all.
- R9: Successive narrow stores to one doubleword accumulate: each store keeps the lanes written by the stores before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_en | input | 1 | A store is issued this cycle |
| st_size | input | 2 | Store size: 00 byte, 10 word, 11 doubleword, 01 reserved |
| byte_off | input | 3 | Byte offset of the store inside its doubleword |
| st_data | input | 64 | Store operand from the second register read port |
| cur_dw | input | 64 | Doubleword the RAM currently returns at the store address |
| wr_data | output | 64 | Merged doubleword for the RAM write port |
| ram_rd_en | output | 1 | RAM read request for the read half of a read-modify-write |
| ram_wr_en | output | 1 | RAM write enable |

## Verification
The block keeps no state, so any fault in lane selection or enable decoding shows on `wr_data` or the enables in the same cycle as the stimulus. One example is a wrong lane index or a half swapped in the word merge. The bench's behavioural RAM makes that fault lasting. A dropped `ram_rd_en` or a lane that is not carried through corrupts the stored doubleword at the next edge. The bench then finds it when it compares the RAM with its own model, and every later merge on that doubleword carries the damage forward.

// File: rtl/rmw_store_pkg.sv
package rmw_store_pkg;
  localparam int DW_BITS   = 64;
  localparam int WORD_BITS = 32;
  localparam int BYTE_BITS = 8;
  localparam int OFF_BITS  = $clog2(DW_BITS / BYTE_BITS);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_RSVD  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } st_size_e;

  typedef enum logic [1:0] {
    PICK_NONE,
    PICK_BYTE,
    PICK_WORD,
    PICK_DWORD
  } pick_e;
endpackage

// File: rtl/rmw_lane_insert.sv
module rmw_lane_insert #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] base,
  input  logic [LANE_W-1:0] ins,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] merged
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] =
      (idx == IDX_W'(l)) ? ins : base[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/rmw_store_ctrl.sv
module rmw_store_ctrl
  import rmw_store_pkg::*;
(
  input  logic       st_en,
  input  st_size_e   size,
  output logic       rd_en,
  output logic       wr_en,
  output pick_e      pick
);
  always_comb begin
    rd_en = 1'b0;
    wr_en = 1'b0;
    pick  = PICK_NONE;
    if (st_en) begin
      case (size)
        SZ_BYTE: begin
          rd_en = 1'b1;
          wr_en = 1'b1;
          pick  = PICK_BYTE;
        end
        SZ_WORD: begin
          rd_en = 1'b1;
          wr_en = 1'b1;
          pick  = PICK_WORD;
        end
        SZ_DWORD: begin
          wr_en = 1'b1;
          pick  = PICK_DWORD;
        end
        default: pick = PICK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_store_merge.sv
module rmw_store_merge
  import rmw_store_pkg::*;
#(
  parameter int DATA_W = DW_BITS,
  localparam int OFF_W = $clog2(DATA_W / BYTE_BITS),
  localparam int WIDX_W = $clog2(DATA_W / WORD_BITS)
) (
  input  logic              st_en,
  input  logic [1:0]        st_size,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] cur_dw,
  output logic [DATA_W-1:0] wr_data,
  output logic              ram_rd_en,
  output logic              ram_wr_en
);
  pick_e             pick;
  logic [DATA_W-1:0] byte_merged;
  logic [DATA_W-1:0] word_merged;

  rmw_store_ctrl u_ctrl (
    .st_en (st_en),
    .size  (st_size_e'(st_size)),
    .rd_en (ram_rd_en),
    .wr_en (ram_wr_en),
    .pick  (pick)
  );

  rmw_lane_insert #(.DATA_W(DATA_W), .LANE_W(BYTE_BITS)) u_byte (
    .base   (cur_dw),
    .ins    (st_data[BYTE_BITS-1:0]),
    .idx    (byte_off),
    .merged (byte_merged)
  );

  rmw_lane_insert #(.DATA_W(DATA_W), .LANE_W(WORD_BITS)) u_word (
    .base   (cur_dw),
    .ins    (st_data[WORD_BITS-1:0]),
    .idx    (byte_off[OFF_W-1 -: WIDX_W]),
    .merged (word_merged)
  );

  always_comb begin
    case (pick)
      PICK_BYTE:  wr_data = byte_merged;
      PICK_WORD:  wr_data = word_merged;
      PICK_DWORD: wr_data = st_data;
      default:    wr_data = cur_dw;
    endcase
  end

  // Checks on the port relations of the merge
  logic [DATA_W-1:0] chk_mask;
  always_comb begin
    chk_mask = DATA_W'(8'hFF) << (BYTE_BITS * byte_off);
    if (!$isunknown({st_en, st_size, byte_off, st_data, cur_dw})) begin
      a_r1_idle_quiet: assert (st_en || (!ram_wr_en && !ram_rd_en))
        else $error("R1: enable raised without a store");
      a_r7_reserved_quiet: assert (!(st_size == 2'b01) || !ram_wr_en)
        else $error("R7: reserved size wrote the RAM");
      a_r6_rmw_pair: assert (!(ram_wr_en && st_size != 2'b11) || ram_rd_en)
        else $error("R6: narrow store without read");
      if (ram_wr_en && st_size == 2'b11) begin
        a_r2_dw_whole: assert (wr_data == st_data && !ram_rd_en)
          else $error("R2: doubleword store altered");
      end
      if (ram_wr_en && st_size == 2'b10) begin
        a_r3_r4_half_kept: assert (byte_off[OFF_W-1] ?
            (wr_data[WORD_BITS-1:0] == cur_dw[WORD_BITS-1:0]) :
            (wr_data[DATA_W-1:WORD_BITS] == cur_dw[DATA_W-1:WORD_BITS]))
          else $error("R3/R4: untouched half changed");
      end
      if (ram_wr_en && st_size == 2'b00) begin
        a_r5_lanes_kept: assert ((((wr_data ^ cur_dw) & ~chk_mask) == '0) &&
            ((wr_data & chk_mask) ==
             (DATA_W'(st_data[BYTE_BITS-1:0]) << (BYTE_BITS * byte_off))))
          else $error("R5: byte merge wrong");
      end
    end
  end
endmodule

// File: tb/rmw_store_merge_bench.sv
module rmw_store_merge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_en = 1'b0;
  logic [1:0]  st_size = 2'b00;
  logic [2:0]  byte_off = 3'd0;
  logic [63:0] st_data = '0;
  logic [63:0] cur_dw;
  logic [63:0] wr_data;
  logic        ram_rd_en, ram_wr_en;
  logic [3:0]  dw_idx = 4'd0;
  logic [63:0] mem [16];
  logic [63:0] ref_mem [16];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rmw_store_merge u_rmw_store_merge (
    .st_en(st_en), .st_size(st_size), .byte_off(byte_off),
    .st_data(st_data), .cur_dw(cur_dw), .wr_data(wr_data),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en)
  );

  // Behavioural RAM: the read data only arrives when the read is requested
  assign cur_dw = ram_rd_en ? mem[dw_idx] : 64'h0;
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else if (ram_wr_en) begin
      mem[dw_idx] <= wr_data;
    end
  end

  function automatic logic [63:0] model_merge(logic [63:0] old, logic [63:0] d,
                                              logic [1:0] sz, logic [2:0] off);
    logic [63:0] r = old;
    case (sz)
      2'b00: r[off*8 +: 8] = d[7:0];
      2'b10: for (int b = 0; b < 4; b++) r[(off[2]*4 + b)*8 +: 8] = d[b*8 +: 8];
      2'b11: r = d;
      default: r = old;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic store(string req, logic en, logic [1:0] sz, logic [3:0] idx,
                       logic [2:0] off, logic [63:0] d);
    logic wr_exp, rd_exp;
    @(negedge clk);
    st_en = en; st_size = sz; dw_idx = idx; byte_off = off; st_data = d;
    wr_exp = en && sz != 2'b01;
    rd_exp = en && (sz == 2'b00 || sz == 2'b10);
    #1;
    check({req, " wr_en"}, 64'(ram_wr_en), 64'(wr_exp));
    check({req, " rd_en"}, 64'(ram_rd_en), 64'(rd_exp));
    if (wr_exp) check({req, " wr_data"}, wr_data,
                      model_merge(ref_mem[idx], d, sz, off));
    @(posedge clk);
    if (wr_exp) ref_mem[idx] = model_merge(ref_mem[idx], d, sz, off);
    #1;
    check({req, " ram"}, mem[idx], ref_mem[idx]);
    st_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 reset wr_en", 64'(ram_wr_en), 64'd0);
    check("R1 reset rd_en", 64'(ram_rd_en), 64'd0);
    // R2 and R8: whole doubleword, offset ignored
    store("R2", 1'b1, 2'b11, 4'd1, 3'd0, 64'h0123_4567_89AB_CDEF);
    store("R8 dw", 1'b1, 2'b11, 4'd2, 3'd5, 64'hFEDC_BA98_7654_3210);
    store("R2", 1'b1, 2'b11, 4'd3, 3'd7, 64'hAAAA_5555_F0F0_0F0F);
    // R3, R4, R8: word halves, low offset bits ignored
    store("R3", 1'b1, 2'b10, 4'd1, 3'd0, 64'hDEAD_BEEF_1111_2222);
    store("R4", 1'b1, 2'b10, 4'd1, 3'd4, 64'hDEAD_BEEF_3333_4444);
    store("R8 word", 1'b1, 2'b10, 4'd2, 3'd3, 64'h0000_0000_CAFE_F00D);
    store("R8 word", 1'b1, 2'b10, 4'd2, 3'd6, 64'h0000_0000_1234_5678);
    // R5, R6, R9: every byte lane, accumulating on one doubleword
    for (int b = 0; b < 8; b++)
      store("R5 R9", 1'b1, 2'b00, 4'd3, 3'(b), 64'hFFFF_FFFF_FFFF_FF00 | 64'(b * 17 + 3));
    store("R6 byte", 1'b1, 2'b00, 4'd0, 3'd5, 64'h77);
    store("R9 word", 1'b1, 2'b10, 4'd3, 3'd4, 64'h0000_0000_0BAD_CAFE);
    // R7: reserved size leaves memory alone
    store("R7", 1'b1, 2'b01, 4'd1, 3'd2, 64'h5A5A_5A5A_5A5A_5A5A);
    // R1: no store active, RAM untouched
    store("R1", 1'b0, 2'b11, 4'd2, 3'd0, 64'h1111_1111_1111_1111);
    store("R1", 1'b0, 2'b00, 4'd3, 3'd1, 64'h22);
    for (int i = 0; i < 16; i++) check("R9 final", mem[i], ref_mem[i]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule